// File: doc/BRIEF.md
# Byte-Write Synchronous Burst SRAM Core

This block is a single-clock static memory. Address, data and control inputs are captured on each rising clock edge. Read data comes out flow-through, in the same cycle that follows the sampling edge, with no further pipeline register. On every edge the chip enables, two burst-start strobes and an advance input are decoded into one of three cycle kinds:

- a deselect;
- the start of a burst at the external address;
- a burst step, which either moves to the next address in the burst or holds the current one.

Writes are masked per byte lane. A global write input writes every lane. A gated path (a byte-write enable plus four lane enables) writes only the chosen lanes.

The two start strobes differ in priority. The processor-side strobe is masked while the primary enable is inactive, and it always starts a read. The controller-side strobe still acts while the primary enable is inactive, where it deselects the device, and it starts a read or a write as the write inputs decide. A 2-bit burst counter steps through the low address bits in either linear or interleaved order. The output is a data word plus a valid flag that stands in for a tri-state bus.

Top module: `syncsram_core`

## Requirements
- R1: After reset the device is deselected, with dataValid low and dataOut all zero. Whenever dataValid is low, dataOut is all zero.
- R2: With gwN low, a write cycle stores all four lanes of dataIn, whatever the values of bweN and bwN.
- R3: With gwN high and bweN low, lane i (bits i*LANE_W+LANE_W-1 down to i*LANE_W, where lane 0 is the low lane and LANE_W is 9 with parity and 8 without) is written only where bwN[i] is low. The other lanes keep their contents.
- R4: With gwN high, and either bweN high or bwN equal to 4'b1111, the cycle is a read and no lane changes.
- R5: While ceN is high, adspN has no effect. In that state adscN low deselects the device, and adscN high performs a burst step.
- R6: ce2 (active high) and ce2N (active low) are looked at only in cycles where a start strobe is accepted. If either one is inactive at that point, the device is deselected and nothing is written. During burst steps both are ignored.
- R7: A burst started with adspN low, and with all enables active, is a read whatever gwN, bweN and bwN say.
- R8: A burst started with adscN low and adspN high is a read or a write as R2 to R4 decode it. Writes go to the external address.
- R9: A burst step with advN low moves to the next burst address. With burstLinear at 1, the low two bits follow base+k modulo 4. With burstLinear at 0, they follow base XOR k. The upper bits keep the base value, and the step after the fourth wraps back to the base.
- R10: A burst step with advN high keeps the current address, and it performs the read or write that R2 to R4 decode.
- R11: Read data is valid in the cycle after its sampling edge, and only while oeN is low. oeN acts without waiting for a clock edge.
- R12: During a write cycle dataValid is low.
- R13: Burst steps taken while deselected leave the device deselected and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| dataIn | input | DATA_W | Write data, four lanes |
| adspN | input | 1 | Processor-side burst start, active low |
| adscN | input | 1 | Controller-side burst start, active low |
| advN | input | 1 | Burst advance, active low |
| ceN | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary enable, active high |
| ce2N | input | 1 | Secondary enable, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Lane write enables, active low, bit 0 is the low lane |
| oeN | input | 1 | Output enable, active low |
| burstLinear | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| dataOut | output | DATA_W | Read data, zero when not valid |
| dataValid | output | 1 | Read data is being driven |

## Verification
A wrong selected-state bit shows up in the very next cycle: dataValid is high after a deselect, or low during a step that should read. A wrong burst counter or base register returns data from a neighbouring word in the cycle right after the step, and the linear and interleaved checks are built so that the two orders differ there. A wrong lane decode stays hidden until the word is read back. For that reason every masked write is followed at once by a read of the same word, and any write that should have been suppressed is followed by a read-back that would expose it.

// File: rtl/syncsram_pkg.sv
package syncsram_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    CYC_IDLE,
    CYC_START,
    CYC_RUN
  } cycKind_t;

  typedef struct packed {
    logic             load;
    logic             adv;
    logic             rdCycle;
    logic [LANES-1:0] laneWe;
  } ctrlStrb_t;
endpackage

// File: rtl/syncsram_burst.sv
module syncsram_burst #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic              load,
  input  logic              adv,
  input  logic              linear,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] cycAddr
);
  logic [ADDR_W-1:0] baseReg;
  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  nextCnt;
  logic [CNT_W-1:0]  useCnt;
  logic [CNT_W-1:0]  lowBits;

  assign nextCnt = cntReg + 1'b1;
  assign useCnt  = adv ? nextCnt : cntReg;

  always_comb begin
    if (linear) lowBits = baseReg[CNT_W-1:0] + useCnt;
    else        lowBits = baseReg[CNT_W-1:0] ^ useCnt;
    if (load) wrAddr = extAddr;
    else      wrAddr = {baseReg[ADDR_W-1:CNT_W], lowBits};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      cntReg  <= '0;
      cycAddr <= '0;
    end else begin
      if (load) begin
        baseReg <= extAddr;
        cntReg  <= '0;
      end else if (adv) begin
        cntReg <= nextCnt;
      end
      cycAddr <= wrAddr;
    end
  end
endmodule

// File: rtl/syncsram_ctrl.sv
module syncsram_ctrl
  import syncsram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             adspN,
  input  logic             adscN,
  input  logic             advN,
  input  logic             ceN,
  input  logic             ce2,
  input  logic             ce2N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  output ctrlStrb_t        strb,
  output logic             rdValid
);
  cycKind_t         kind;
  logic             fromP;
  logic             secOk;
  logic             selReg;
  logic             live;
  logic             writeOk;
  logic [LANES-1:0] laneSel;

  always_comb begin
    laneSel = '0;
    if (!gwN)       laneSel = '1;
    else if (!bweN) laneSel = ~bwN;
    secOk = ce2 & ~ce2N;
    kind  = CYC_RUN;
    fromP = 1'b0;
    if (ceN) begin
      if (!adscN) kind = CYC_IDLE;
    end else if (!adspN) begin
      kind  = secOk ? CYC_START : CYC_IDLE;
      fromP = 1'b1;
    end else if (!adscN) begin
      kind = secOk ? CYC_START : CYC_IDLE;
    end
  end

  always_comb begin
    live         = (kind == CYC_RUN) && selReg;
    writeOk      = ((kind == CYC_START) && !fromP) || live;
    strb.load    = (kind == CYC_START);
    strb.adv     = live && !advN;
    strb.laneWe  = writeOk ? laneSel : '0;
    strb.rdCycle = ((kind == CYC_START) && fromP) || (writeOk && !(|laneSel));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg  <= 1'b0;
      rdValid <= 1'b0;
    end else begin
      if (kind == CYC_START)     selReg <= 1'b1;
      else if (kind == CYC_IDLE) selReg <= 1'b0;
      rdValid <= strb.rdCycle;
    end
  end
endmodule

// File: rtl/syncsram_dpath.sv
module syncsram_dpath #(
  parameter int ADDR_W = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        laneWe,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES*LANE_W-1:0] dataIn,
  input  logic [ADDR_W-1:0]       cycAddr,
  input  logic                    rdValid,
  input  logic                    oeN,
  output logic [LANES*LANE_W-1:0] dataOut,
  output logic                    dataValid
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (laneWe[i]) mem[wrAddr][i*LANE_W +: LANE_W] <= dataIn[i*LANE_W +: LANE_W];
    end
  end

  assign dataValid = rdValid & ~oeN;
  assign dataOut   = dataValid ? mem[cycAddr] : '0;
endmodule

// File: rtl/syncsram_core.sv
module syncsram_core
  import syncsram_pkg::*;
#(
  parameter int  ADDR_W    = 8,
  parameter bit  PARITY_EN = 1'b1,
  localparam int LANE_W    = PARITY_EN ? 9 : 8,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              adspN,
  input  logic              adscN,
  input  logic              advN,
  input  logic              ceN,
  input  logic              ce2,
  input  logic              ce2N,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              burstLinear,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataValid
);
  ctrlStrb_t         strb;
  logic              rdValid;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] cycAddr;

  syncsram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .adspN(adspN), .adscN(adscN), .advN(advN),
    .ceN(ceN), .ce2(ce2), .ce2N(ce2N), .gwN(gwN), .bweN(bweN), .bwN(bwN),
    .strb(strb), .rdValid(rdValid)
  );

  syncsram_burst #(.ADDR_W(ADDR_W), .CNT_W(2)) u_burst (
    .clk(clk), .rstN(rstN), .extAddr(addr), .load(strb.load), .adv(strb.adv),
    .linear(burstLinear), .wrAddr(wrAddr), .cycAddr(cycAddr)
  );

  syncsram_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_dpath (
    .clk(clk), .laneWe(strb.laneWe), .wrAddr(wrAddr), .dataIn(dataIn),
    .cycAddr(cycAddr), .rdValid(rdValid), .oeN(oeN),
    .dataOut(dataOut), .dataValid(dataValid)
  );
endmodule

// File: rtl/syncsram_chk.sv
module syncsram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rstN,
  input logic              ceN,
  input logic              adspN,
  input logic              adscN,
  input logic              ce2,
  input logic              ce2N,
  input logic              gwN,
  input logic              oeN,
  input logic              dataValid,
  input logic [DATA_W-1:0] dataOut
);
  // R1
  zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataValid |-> dataOut == '0);

  // R11
  oe_gates_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dataValid);

  // R5
  adsc_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ceN && !adscN) |=> !dataValid);

  // R6
  sec_desel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !adspN && !ce2) |=> !dataValid);

  // R7
  adsp_forces_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !adspN && ce2 && !ce2N) |=> (oeN || dataValid));

  // R12
  write_hides_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && adspN && !adscN && ce2 && !ce2N && !gwN) |=> !dataValid);
endmodule

bind syncsram_core syncsram_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .adspN(adspN), .adscN(adscN),
  .ce2(ce2), .ce2N(ce2N), .gwN(gwN), .oeN(oeN),
  .dataValid(dataValid), .dataOut(dataOut)
);

// File: tb/syncsram_core_bench.sv
module syncsram_core_bench;
  localparam int AW = 4;
  localparam int LW = 9;
  localparam int DW = 4 * LW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic [DW-1:0] dataIn;
  logic          adspN, adscN, advN, ceN, ce2, ce2N, gwN, bweN, oeN, burstLinear;
  logic [3:0]    bwN;
  logic [DW-1:0] dataOut;
  logic          dataValid;

  logic [DW-1:0] refMem [1 << AW];
  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  syncsram_core #(.ADDR_W(AW), .PARITY_EN(1'b1)) u_syncsram_core (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .adspN(adspN),
    .adscN(adscN), .advN(advN), .ceN(ceN), .ce2(ce2), .ce2N(ce2N), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .oeN(oeN), .burstLinear(burstLinear),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setIdle();
    ceN = 1; adspN = 1; adscN = 1; advN = 1; ce2 = 1; ce2N = 0;
    gwN = 1; bweN = 1; bwN = 4'hf; oeN = 0; dataIn = '0; addr = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expRead(input string req, input logic [AW-1:0] a);
    chk({req, " valid"}, {35'd0, dataValid}, 36'd1);
    chk(req, dataOut, refMem[a]);
  endtask

  task automatic expIdle(input string req);
    chk({req, " valid"}, {35'd0, dataValid}, 36'd0);
    chk({req, " zero"}, dataOut, '0);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                          input logic g, input logic b, input logic [3:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++)
      if (!g || (!b && !m[i])) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  function automatic logic [AW-1:0] seqAddr(input logic [AW-1:0] b, input int k, input logic lin);
    logic [1:0] lo = lin ? b[1:0] + 2'(k) : b[1:0] ^ 2'(k);
    return {b[AW-1:2], lo};
  endfunction

  // Begin with the controller-side strobe; R2, R3, R4, R8, R12
  task automatic startC(input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic g, input logic b, input logic [3:0] m);
    logic isWr = !g || (!b && m != 4'hf);
    setIdle(); ceN = 0; adscN = 0; addr = a; dataIn = d; gwN = g; bweN = b; bwN = m;
    tick();
    if (isWr) begin
      refMem[a] = merge(refMem[a], d, g, b, m);
      expIdle("R12 write cycle");
    end else begin
      expRead("R4 R8 read start", a);
    end
    setIdle();
  endtask

  // Begin with the processor-side strobe while write inputs are active; R7
  task automatic startP(input logic [AW-1:0] a);
    setIdle(); ceN = 0; adspN = 0; addr = a; gwN = 0; bweN = 0; bwN = 4'h0;
    dataIn = ~refMem[a];
    tick();
    expRead("R7 forced read", a);
    setIdle();
  endtask

  task automatic stepRead(input string req, input logic adv, input logic [AW-1:0] a);
    setIdle(); advN = !adv;
    tick();
    expRead(req, a);
  endtask

  task automatic tReset();
    expIdle("R1 reset");
  endtask

  task automatic tFill();
    for (int i = 0; i < 16; i++)
      startC(AW'(i), {4'(i), 32'hC0DE0000 | (i * 32'h01010101)}, 1'b0, 1'b1, 4'hf);
  endtask

  task automatic tLanes();
    startC(4'd4, 36'hF_1111_2222, 1'b0, 1'b1, 4'hf);           // R2
    startP(4'd4);
    startC(4'd5, 36'hA_BBCC_DDEE, 1'b1, 1'b0, 4'b1010);        // R3
    startP(4'd5);
    startC(4'd6, 36'h5_5555_5555, 1'b1, 1'b1, 4'h0);           // R4
    startC(4'd7, 36'h5_5555_5555, 1'b1, 1'b0, 4'hf);           // R4
    startP(4'd6);
    startP(4'd7);
  endtask

  task automatic tOutEnable();
    setIdle(); ceN = 0; adspN = 0; addr = 4'd2; oeN = 1;
    tick();
    expIdle("R11 oe high");
    oeN = 0;
    #1;
    expRead("R11 oe async", 4'd2);
    setIdle();
  endtask

  task automatic tPrimary();
    startP(4'd9);
    setIdle(); adspN = 0; addr = 4'd12;
    tick();
    expRead("R5 adsp ignored", 4'd9);
    setIdle(); adscN = 0;
    tick();
    expIdle("R5 adsc deselect");
    setIdle(); advN = 0; gwN = 0; dataIn = 36'h0_DEAD_BEEF;
    tick();
    expIdle("R13 stays deselected");
    startP(4'd9);
    chk("R13 no write", dataOut, refMem[9]);
  endtask

  task automatic tSecondary();
    setIdle(); ceN = 0; adspN = 0; ce2 = 0; addr = 4'd1;
    tick();
    expIdle("R6 adsp ce2 low");
    setIdle(); ceN = 0; adscN = 0; ce2N = 1; gwN = 0; addr = 4'd1; dataIn = 36'h0_BAD0_BAD0;
    tick();
    expIdle("R6 adsc ce2N high");
    startP(4'd1);
    burstLinear = 1;
    startP(4'd8);
    setIdle(); advN = 0; ce2 = 0; ce2N = 1;
    tick();
    expRead("R6 ignored in step", 4'd9);
    setIdle();
  endtask

  task automatic tOrder(input logic lin);
    burstLinear = lin;
    startP(4'd9);
    for (int k = 1; k <= 4; k++)
      stepRead(lin ? "R9 linear" : "R9 interleaved", 1'b1, seqAddr(4'd9, k, lin));
  endtask

  task automatic tSuspend();
    burstLinear = 1;
    startP(4'd13);
    stepRead("R10 hold", 1'b0, 4'd13);
    setIdle(); gwN = 0; dataIn = 36'h3_0F0F_0F0F;
    tick();
    refMem[13] = 36'h3_0F0F_0F0F;
    expIdle("R10 suspend write");
    stepRead("R10 hold after write", 1'b0, 4'd13);
  endtask

  task automatic tBurstWrite();
    burstLinear = 1;
    startC(4'd14, 36'h1_0000_0001, 1'b0, 1'b1, 4'hf);
    for (int k = 1; k <= 2; k++) begin
      setIdle(); advN = 0; gwN = 0; dataIn = 36'h2_0000_0000 | 36'(k);
      tick();
      refMem[seqAddr(4'd14, k, 1'b1)] = 36'h2_0000_0000 | 36'(k);
      expIdle("R8 R9 burst write step");
    end
    startP(4'd14);
    startP(4'd15);
    startP(4'd12);
  endtask

  initial begin
    #(200000 * 8);
    nChecks++;
    nFails++;
    $display("FAIL watchdog all: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    setIdle();
    burstLinear = 1;
    rstN = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    tick();
    tReset();
    tFill();
    tLanes();
    tOutEnable();
    tPrimary();
    tSecondary();
    tOrder(1'b1);
    tOrder(1'b0);
    tSuspend();
    tBurstWrite();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule